// File: doc/BRIEF.md
# Calendar Real-Time Clock Counter

The block keeps wall-clock time and a full calendar from a slow timebase tick. Each `tick_i` pulse, sampled on the system clock, advances a sub-second prescaler. When the prescaler completes a second, the seconds field steps. The step carries through minutes and hours into the day fields. The day fields are day of month, month, year, day of week and day of year. The day-of-week and day-of-year counters step in the same cycle as the date, so they never disagree with it.

Software reads every field directly from the output ports. It presets the calendar by placing a complete set of values on the `*_set_i` inputs and raising `wr_en_i` for one cycle. That load also restarts the sub-second count, so the first second after a preset is a full second. `sec_pulse_o` gives a one-cycle marker for every seconds step, for use by neighbouring logic.

Top module: `cal_rtc`

## Requirements
- R1: One second elapses after exactly TICKS_PER_SEC (default 32768) cycles with `tick_i` high. Clock cycles with `tick_i` low do not count.
- R2: Seconds and minutes wrap from 59 to 0, and each wrap steps the next field. Hours wrap from 23 to 0, and that wrap starts a new day.
- R3: On a new day, day of month wraps to 1 after the length of the current month. Months 4, 6, 9 and 11 have 30 days. Month 2 has 28 days, or 29 when bits [1:0] of the year are 0. All other months have 31 days.
- R4: Month wraps from 12 to 1, and that wrap increments the year.
- R5: Day of week steps once per new day and wraps from 6 to 0.
- R6: Day of year steps once per new day. It returns to 1 after 365, or after 366 in a leap year.
- R7: `sec_pulse_o` is high for exactly one cycle: the first cycle in which the new seconds value is visible. In every other cycle without a load, all fields hold.
- R8: A cycle with `wr_en_i` high loads all eight fields from the `*_set_i` inputs. The values are visible in the next cycle.
- R9: A load clears the prescaler. A load takes priority over a tick in the same cycle, so that cycle gives no step and no pulse.
- R10: After reset the time is 00:00:00, day 1 of month 1, year 0, weekday 0, day of year 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timebase tick enable, 32.768 kHz rate |
| wr_en_i | input | 1 | Load all fields from the preset inputs |
| sec_set_i | input | 6 | Preset seconds |
| min_set_i | input | 6 | Preset minutes |
| hour_set_i | input | 5 | Preset hours |
| mday_set_i | input | 5 | Preset day of month |
| mon_set_i | input | 4 | Preset month |
| year_set_i | input | YEAR_W | Preset year |
| wday_set_i | input | 3 | Preset day of week |
| yday_set_i | input | 9 | Preset day of year |
| sec_o | output | 6 | Seconds |
| min_o | output | 6 | Minutes |
| hour_o | output | 5 | Hours |
| mday_o | output | 5 | Day of month |
| mon_o | output | 4 | Month |
| year_o | output | YEAR_W | Year |
| wday_o | output | 3 | Day of week |
| yday_o | output | 9 | Day of year |
| sec_pulse_o | output | 1 | One-cycle marker of a seconds step |

## Verification
Month-end, leap-day and year-end carries normally need days or years of ticks to reach. Such a run is out of reach at the ports. The stimulus instead presets the clock to one second before each boundary: 23:59:59 on the last day of a 30-day month, February in a leap and a common year, and December 31 of both year kinds. It then applies one second of ticks. That main instance uses a four-tick second. A second instance at the default rate confirms the full 32768-tick second once. Loads are also placed mid-second and on the same cycle as the completing tick.

// File: rtl/cal_rtc_pkg.sv
package cal_rtc_pkg;
  localparam int SEC_W  = 6;
  localparam int MIN_W  = 6;
  localparam int HOUR_W = 5;
  localparam int DOM_W  = 5;
  localparam int MON_W  = 4;
  localparam int DOW_W  = 3;
  localparam int DOY_W  = 9;

  function automatic logic [DOM_W-1:0] month_days(input logic [MON_W-1:0] mon,
                                                  input logic leap);
    case (mon)
      4'd2:                   return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
      default:                return 5'd31;
    endcase
  endfunction
endpackage

// File: rtl/cal_rtc_prescaler.sv
module cal_rtc_prescaler #(
  parameter int TICKS_PER_SEC = 32768,
  localparam int PRE_W = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic tick_i,
  output logic sec_step_o
);
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICKS_PER_SEC - 1);

  logic [PRE_W-1:0] cnt_q;
  logic             at_last;

  assign at_last    = (cnt_q == LAST);
  assign sec_step_o = tick_i & at_last & ~clr_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tick_i) cnt_q <= at_last ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/cal_rtc_field.sv
module cal_rtc_field #(
  parameter int W       = 6,
  parameter int MIN_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         step_i,
  input  logic [W-1:0] max_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);
  localparam logic [W-1:0] LOW = W'(MIN_VAL);

  logic wrap;
  // >= rather than == so an out-of-range preset still recovers
  assign wrap    = (q_o >= max_i);
  assign carry_o = step_i & wrap & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= LOW;
    else if (load_i) q_o <= load_val_i;
    else if (step_i) q_o <= wrap ? LOW : q_o + 1'b1;
  end
endmodule

// File: rtl/cal_rtc_limits.sv
module cal_rtc_limits import cal_rtc_pkg::*; #(
  parameter int YEAR_W = 12
) (
  input  logic [MON_W-1:0]  mon_i,
  input  logic [YEAR_W-1:0] year_i,
  output logic [DOM_W-1:0]  mday_max_o,
  output logic [DOY_W-1:0]  yday_max_o
);
  logic leap;
  assign leap       = (year_i[1:0] == 2'b00);
  assign mday_max_o = month_days(mon_i, leap);
  assign yday_max_o = leap ? 9'd366 : 9'd365;
endmodule

// File: rtl/cal_rtc.sv
module cal_rtc import cal_rtc_pkg::*; #(
  parameter int TICKS_PER_SEC = 32768,
  parameter int YEAR_W        = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [SEC_W-1:0]  sec_set_i,
  input  logic [MIN_W-1:0]  min_set_i,
  input  logic [HOUR_W-1:0] hour_set_i,
  input  logic [DOM_W-1:0]  mday_set_i,
  input  logic [MON_W-1:0]  mon_set_i,
  input  logic [YEAR_W-1:0] year_set_i,
  input  logic [DOW_W-1:0]  wday_set_i,
  input  logic [DOY_W-1:0]  yday_set_i,
  output logic [SEC_W-1:0]  sec_o,
  output logic [MIN_W-1:0]  min_o,
  output logic [HOUR_W-1:0] hour_o,
  output logic [DOM_W-1:0]  mday_o,
  output logic [MON_W-1:0]  mon_o,
  output logic [YEAR_W-1:0] year_o,
  output logic [DOW_W-1:0]  wday_o,
  output logic [DOY_W-1:0]  yday_o,
  output logic              sec_pulse_o
);
  logic sec_step, sec_c, min_c, day_step, mday_c, mon_c, year_c, wday_c, yday_c;
  logic [DOM_W-1:0] mday_max;
  logic [DOY_W-1:0] yday_max;

  cal_rtc_prescaler #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_pre (
    .clk_i, .rst_ni, .clr_i(wr_en_i), .tick_i, .sec_step_o(sec_step)
  );

  cal_rtc_limits #(.YEAR_W(YEAR_W)) u_lim (
    .mon_i(mon_o), .year_i(year_o), .mday_max_o(mday_max), .yday_max_o(yday_max)
  );

  cal_rtc_field #(.W(SEC_W), .MIN_VAL(0)) u_sec (
    .clk_i, .rst_ni, .load_i(wr_en_i), .load_val_i(sec_set_i), .step_i(sec_step),
    .max_i(6'd59), .q_o(sec_o), .carry_o(sec_c)
  );
  cal_rtc_field #(.W(MIN_W), .MIN_VAL(0)) u_min (
    .clk_i, .rst_ni, .load_i(wr_en_i), .load_val_i(min_set_i), .step_i(sec_c),
    .max_i(6'd59), .q_o(min_o), .carry_o(min_c)
  );
  cal_rtc_field #(.W(HOUR_W), .MIN_VAL(0)) u_hour (
    .clk_i, .rst_ni, .load_i(wr_en_i), .load_val_i(hour_set_i), .step_i(min_c),
    .max_i(5'd23), .q_o(hour_o), .carry_o(day_step)
  );
  cal_rtc_field #(.W(DOM_W), .MIN_VAL(1)) u_mday (
    .clk_i, .rst_ni, .load_i(wr_en_i), .load_val_i(mday_set_i), .step_i(day_step),
    .max_i(mday_max), .q_o(mday_o), .carry_o(mday_c)
  );
  cal_rtc_field #(.W(MON_W), .MIN_VAL(1)) u_mon (
    .clk_i, .rst_ni, .load_i(wr_en_i), .load_val_i(mon_set_i), .step_i(mday_c),
    .max_i(4'd12), .q_o(mon_o), .carry_o(mon_c)
  );
  cal_rtc_field #(.W(YEAR_W), .MIN_VAL(0)) u_year (
    .clk_i, .rst_ni, .load_i(wr_en_i), .load_val_i(year_set_i), .step_i(mon_c),
    .max_i({YEAR_W{1'b1}}), .q_o(year_o), .carry_o(year_c)
  );
  cal_rtc_field #(.W(DOW_W), .MIN_VAL(0)) u_wday (
    .clk_i, .rst_ni, .load_i(wr_en_i), .load_val_i(wday_set_i), .step_i(day_step),
    .max_i(3'd6), .q_o(wday_o), .carry_o(wday_c)
  );
  // year read before its own step: Dec 31 uses the ending year's length
  cal_rtc_field #(.W(DOY_W), .MIN_VAL(1)) u_yday (
    .clk_i, .rst_ni, .load_i(wr_en_i), .load_val_i(yday_set_i), .step_i(day_step),
    .max_i(yday_max), .q_o(yday_o), .carry_o(yday_c)
  );

  logic unused_c;
  assign unused_c = year_c ^ wday_c ^ yday_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sec_pulse_o <= 1'b0;
    else         sec_pulse_o <= sec_step;
  end
endmodule

// File: rtl/cal_rtc_chk.sv
module cal_rtc_chk #(
  parameter int YEAR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [5:0]        sec_set_i,
  input logic [5:0]        min_set_i,
  input logic [4:0]        hour_set_i,
  input logic [4:0]        mday_set_i,
  input logic [3:0]        mon_set_i,
  input logic [YEAR_W-1:0] year_set_i,
  input logic [2:0]        wday_set_i,
  input logic [8:0]        yday_set_i,
  input logic [5:0]        sec_o,
  input logic [5:0]        min_o,
  input logic [4:0]        hour_o,
  input logic [4:0]        mday_o,
  input logic [3:0]        mon_o,
  input logic [YEAR_W-1:0] year_o,
  input logic [2:0]        wday_o,
  input logic [8:0]        yday_o,
  input logic              sec_pulse_o
);
  a_r8_load_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wr_en_i) && $past(rst_ni)) |->
      (sec_o == $past(sec_set_i) && min_o == $past(min_set_i) &&
       hour_o == $past(hour_set_i) && mday_o == $past(mday_set_i) &&
       mon_o == $past(mon_set_i) && year_o == $past(year_set_i) &&
       wday_o == $past(wday_set_i) && yday_o == $past(yday_set_i)));

  a_r9_no_pulse_on_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) |-> !sec_pulse_o);

  a_r7_pulse_moves_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_pulse_o |-> !$stable(sec_o));

  a_r7_hold_without_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sec_pulse_o && !$past(wr_en_i)) |->
      ($stable(sec_o) && $stable(min_o) && $stable(hour_o) && $stable(mday_o) &&
       $stable(mon_o) && $stable(year_o) && $stable(wday_o) && $stable(yday_o)));

  a_r2_sec_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_pulse_o && $past(sec_o) == 6'd59) |-> (sec_o == 6'd0 && !$stable(min_o)));

  a_r5_r6_day_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i) |-> ($stable(wday_o) == $stable(yday_o)));

  a_r5_wday_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(wr_en_i) && $past(wday_o) == 3'd6 && !$stable(wday_o)) |-> wday_o == 3'd0);
endmodule

bind cal_rtc cal_rtc_chk #(.YEAR_W(YEAR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
  .sec_set_i(sec_set_i), .min_set_i(min_set_i), .hour_set_i(hour_set_i),
  .mday_set_i(mday_set_i), .mon_set_i(mon_set_i), .year_set_i(year_set_i),
  .wday_set_i(wday_set_i), .yday_set_i(yday_set_i),
  .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .mday_o(mday_o), .mon_o(mon_o),
  .year_o(year_o), .wday_o(wday_o), .yday_o(yday_o), .sec_pulse_o(sec_pulse_o)
);

// File: tb/cal_rtc_test.sv
`timescale 1ns/1ps
module cal_rtc_test;
  localparam int FAST = 4;
  localparam int NV   = 11;
  // preset: sec min hour mday mon year wday yday | expected one second later
  localparam int VEC [NV][16] = '{
    '{ 5, 0, 0, 1, 1,2023,0,  1,   6, 0, 0, 1, 1,2023,0,  1},
    '{59,34,12, 3, 3,2023,2, 62,   0,35,12, 3, 3,2023,2, 62},
    '{59,59,12, 3, 3,2023,2, 62,   0, 0,13, 3, 3,2023,2, 62},
    '{59,59,23,15, 6,2023,3,166,   0, 0, 0,16, 6,2023,4,167},
    '{59,59,23,30, 4,2023,6,120,   0, 0, 0, 1, 5,2023,0,121},
    '{59,59,23,28, 2,2023,1, 59,   0, 0, 0, 1, 3,2023,2, 60},
    '{59,59,23,28, 2,2024,2, 59,   0, 0, 0,29, 2,2024,3, 60},
    '{59,59,23,29, 2,2024,3, 60,   0, 0, 0, 1, 3,2024,4, 61},
    '{59,59,23,31,12,2023,6,365,   0, 0, 0, 1, 1,2024,0,  1},
    '{59,59,23,31,12,2024,1,366,   0, 0, 0, 1, 1,2025,2,  1},
    '{59,59,23,31, 1,2025,4, 31,   0, 0, 0, 1, 2,2025,5, 32}
  };

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, tick_full = 1'b0;
  logic [5:0] s_set = '0, m_set = '0;
  logic [4:0] h_set = '0, d_set = '0;
  logic [3:0] mo_set = '0;
  logic [11:0] y_set = '0;
  logic [2:0] wd_set = '0;
  logic [8:0] yd_set = '0;
  logic [5:0] sec, mn, f_sec, f_mn;
  logic [4:0] hr, md, f_hr, f_md;
  logic [3:0] mo, f_mo;
  logic [11:0] yr, f_yr;
  logic [2:0] wd, f_wd;
  logic [8:0] yd, f_yd;
  logic pulse, f_pulse;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cal_rtc #(.TICKS_PER_SEC(FAST), .YEAR_W(12)) uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .sec_set_i(s_set), .min_set_i(m_set), .hour_set_i(h_set), .mday_set_i(d_set),
    .mon_set_i(mo_set), .year_set_i(y_set), .wday_set_i(wd_set), .yday_set_i(yd_set),
    .sec_o(sec), .min_o(mn), .hour_o(hr), .mday_o(md), .mon_o(mo), .year_o(yr),
    .wday_o(wd), .yday_o(yd), .sec_pulse_o(pulse)
  );

  cal_rtc uut_full (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_full), .wr_en_i(1'b0),
    .sec_set_i(6'd0), .min_set_i(6'd0), .hour_set_i(5'd0), .mday_set_i(5'd0),
    .mon_set_i(4'd0), .year_set_i(12'd0), .wday_set_i(3'd0), .yday_set_i(9'd0),
    .sec_o(f_sec), .min_o(f_mn), .hour_o(f_hr), .mday_o(f_md), .mon_o(f_mo),
    .year_o(f_yr), .wday_o(f_wd), .yday_o(f_yd), .sec_pulse_o(f_pulse)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int e[8]);
    int a[8];
    a = '{int'(sec), int'(mn), int'(hr), int'(md), int'(mo), int'(yr), int'(wd), int'(yd)};
    n_chk++;
    if (a != e) begin
      n_bad++;
      $display("FAIL %s: actual %0d:%0d:%0d %0d/%0d/%0d wd%0d yd%0d expected %0d:%0d:%0d %0d/%0d/%0d wd%0d yd%0d",
               req, a[2], a[1], a[0], a[3], a[4], a[5], a[6], a[7],
               e[2], e[1], e[0], e[3], e[4], e[5], e[6], e[7]);
    end
  endtask

  task automatic load(input int v[8]);
    @(negedge clk);
    s_set = 6'(v[0]); m_set = 6'(v[1]); h_set = 5'(v[2]); d_set = 5'(v[3]);
    mo_set = 4'(v[4]); y_set = 12'(v[5]); wd_set = 3'(v[6]); yd_set = 9'(v[7]);
    wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #950000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int pre[8], exp[8];
    repeat (3) @(negedge clk);
    // R10 reset state
    chk_all("R10 reset values", '{0, 0, 0, 1, 1, 0, 0, 1});
    chk("R10 pulse low at reset", int'(pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      for (int k = 0; k < 8; k++) begin
        pre[k] = VEC[i][k];
        exp[k] = VEC[i][k+8];
      end
      load(pre);
      chk_all($sformatf("R8 load vec %0d", i), pre);
      ticks(FAST - 1);
      chk($sformatf("R7 no early pulse vec %0d", i), int'(pulse), 0);
      chk($sformatf("R1 sec held before full second vec %0d", i), int'(sec), pre[0]);
      ticks(1);
      chk($sformatf("R7 pulse on step vec %0d", i), int'(pulse), 1);
      chk_all($sformatf("R2 R3 R4 R5 R6 rollover vec %0d", i), exp);
      @(negedge clk);
      chk($sformatf("R7 pulse one cycle vec %0d", i), int'(pulse), 0);
    end

    // R1: idle cycles between ticks do not count
    load('{0, 0, 0, 1, 1, 2023, 0, 1});
    for (int t = 0; t < FAST; t++) begin
      tick = 1'b1; @(negedge clk);
      tick = 1'b0; repeat (2) @(negedge clk);
      if (t == FAST - 2) chk("R1 gapped ticks no step yet", int'(sec), 0);
    end
    chk("R1 gapped ticks one second", int'(sec), 1);

    // R9: mid-second load restarts the prescaler
    load('{0, 0, 0, 1, 1, 2023, 0, 1});
    ticks(FAST - 1);
    load('{10, 0, 0, 1, 1, 2023, 0, 1});
    ticks(FAST - 1);
    chk("R9 prescaler cleared by load", int'(sec), 10);
    ticks(1);
    chk("R9 full second after load", int'(sec), 11);

    // R9: load and completing tick in the same cycle
    load('{20, 0, 0, 1, 1, 2023, 0, 1});
    ticks(FAST - 1);
    @(negedge clk);
    s_set = 6'd40; wr_en = 1'b1; tick = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
    chk("R9 load wins over tick", int'(sec), 40);
    chk("R9 no pulse with load", int'(pulse), 0);
    ticks(FAST);
    chk("R9 next second counted from load", int'(sec), 41);

    // R1: default rate needs 32768 ticks
    tick_full = 1'b1;
    repeat (32767) @(negedge clk);
    chk("R1 default rate 32767 ticks", int'(f_sec), 0);
    @(negedge clk);
    tick_full = 1'b0;
    chk("R1 default rate 32768 ticks", int'(f_sec), 1);
    chk("R7 default rate pulse", int'(f_pulse), 1);

    finish_run();
  end
endmodule